// File: doc/BRIEF.md
# Long-press reset timer controller

This block turns a push-button into a hard-reset request. The button only reaches the reset output if it stays pressed for the whole setup delay, counted in millisecond ticks. A short press never asserts reset, so the same button can also feed an interrupt line elsewhere. Two release policies are available through a parameter. In fixed-pulse mode the reset lasts a set number of ticks, whenever the button is let go. In follow mode the reset lasts as long as the button stays pressed.

A comparator outside this block flags an overvoltage on the button pin. When that flag rises, the block latches into test mode and counts a short initial delay. When that delay ends, it asserts reset as a visible sign that test mode was entered. In test mode, each later press needs only the setup delay divided by 128. Only the synchronous power-on reset clears test mode.

The controller is a single state machine with these states:
- IDLE: waits for a press.
- HOLD: counts how long the button is held.
- PULSE: drives the fixed-width reset.
- FOLLOW: holds reset until the button is released.
- WAIT_REL: after a reset, waits for the button to be released.
- TEST_INIT: counts the initial delay on entry to test mode.
- OV_HOLD: holds reset while the overvoltage flag stays true.

The transitions are:
- IDLE goes to HOLD on a press.
- HOLD goes back to IDLE on a release.
- HOLD goes to PULSE or FOLLOW when the hold delay expires.
- PULSE goes to WAIT_REL when the pulse ends.
- FOLLOW goes to IDLE on a release.
- WAIT_REL goes to IDLE on a release.
- TEST_INIT goes to PULSE or OV_HOLD when its delay expires.
- OV_HOLD goes to WAIT_REL when the overvoltage flag clears.
- Any state goes to TEST_INIT when the synchronized flag rises while test mode is not yet latched.

Top module: `lpress_rst_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it is released, `rst_out_n` is 1 and `test_mode` is 0.
- R2: A press released before `HOLD_MS` ticks have elapsed never asserts reset. The hold count restarts at zero on the next press.
- R3: With the button (`btn_n` = 0 is pressed) held continuously, `rst_out_n` falls on the clock edge of the `HOLD_MS`-th tick counted while held. It stays high for all earlier ticks. Inputs pass through a two-flop synchronizer before the state machine.
- R4: With `FIXED_PULSE` = 0, reset stays asserted until the synchronized button reads released, and then deasserts.
- R5: With `FIXED_PULSE` = 1, reset stays asserted for exactly `PULSE_MS` ticks, whether the button is released early or held.
- R6: With `FIXED_PULSE` = 1, a button still held after the pulse does not assert reset again. A new reset needs a release followed by a full-length press.
- R7: A rising `ovp_flag` sets `test_mode` and starts a count of `TEST_INIT_MS` ticks. Reset stays high during that count and asserts on its last tick. With `FIXED_PULSE` = 1 the reset lasts `PULSE_MS` ticks. With `FIXED_PULSE` = 0 it lasts until `ovp_flag` falls.
- R8: In test mode, a press asserts reset after `HOLD_MS` >> 7 ticks (at least one tick) instead of `HOLD_MS`.
- R9: Once set, `test_mode` stays 1 whatever `ovp_flag` and `btn_n` do. Only `rst_n` clears it, which brings back the full hold delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous power-on reset, active low |
| btn_n | input | 1 | Push-button level, asynchronous, active low |
| ovp_flag | input | 1 | Overvoltage indication on the button pin, asynchronous, active high |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| rst_out_n | output | 1 | Hard-reset output, active low, registered |
| test_mode | output | 1 | Latched test-mode indication |

## Verification
The bench sweeps press lengths from zero ticks up to one tick short of the delay. This separates a correct hold count from one that is off by one or fails to clear. Full-length presses followed by an early release or by a long hold tell the two release policies apart, and show whether the fixed pulse re-triggers. Both policies run side by side on the same stimulus. An overvoltage sequence with later one-tick and two-tick presses checks the initial test delay, the shortened hold delay and the latch. A final power-on reset shows that the normal delay returns.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HOLD      = 3'd1,
        ST_PULSE     = 3'd2,
        ST_FOLLOW    = 3'd3,
        ST_WAIT_REL  = 3'd4,
        ST_TEST_INIT = 3'd5,
        ST_OV_HOLD   = 3'd6
    } lpr_state_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lpr_sync.sv
module lpr_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[s] <= INIT;
                end else if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/lpr_tick_count.sv
module lpr_tick_count #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/lpress_rst_ctrl.sv
module lpress_rst_ctrl #(
    parameter int unsigned HOLD_MS      = 2000,
    parameter int unsigned TEST_INIT_MS = 42,
    parameter int unsigned PULSE_MS     = 210,
    parameter int unsigned DIV_SHIFT    = 7,
    parameter bit          FIXED_PULSE  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_n,
    input  logic ovp_flag,
    input  logic tick_ms,
    output logic rst_out_n,
    output logic test_mode
);
    import lpr_pkg::*;

    localparam int unsigned SHORT_RAW = HOLD_MS >> DIV_SHIFT;
    localparam int unsigned SHORT_MS  = (SHORT_RAW == 0) ? 1 : SHORT_RAW;
    localparam int unsigned MAX_MS    = max3(HOLD_MS, TEST_INIT_MS, PULSE_MS);
    localparam int unsigned CNT_W     = $clog2(MAX_MS + 1);

    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_MS - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_MS - 1);
    localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(TEST_INIT_MS - 1);
    localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_MS - 1);

    // Synchronized inputs: bit 1 is button (idle high), bit 0 is overvoltage
    logic [1:0] sync_q;
    logic       btn_s;
    logic       ovp_s;

    lpr_sync #(
        .WIDTH (2),
        .STAGES(2),
        .INIT  (2'b10)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({btn_n, ovp_flag}),
        .q_sync (sync_q)
    );

    assign btn_s = sync_q[1];
    assign ovp_s = sync_q[0];

    lpr_state_e       state_q, state_d;
    logic             test_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic             expire;
    logic             cnt_clr;

    assign cnt_clr = (state_d != state_q);

    lpr_tick_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .tick (tick_ms),
        .count(cnt)
    );

    // Terminal count for the interval of the current state
    always_comb begin
        unique case (state_q)
            ST_HOLD:      last_cnt = test_q ? SHORT_LAST : HOLD_LAST;
            ST_PULSE:     last_cnt = PULSE_LAST;
            ST_TEST_INIT: last_cnt = INIT_LAST;
            default:      last_cnt = HOLD_LAST;
        endcase
    end

    assign expire = tick_ms && (cnt == last_cnt);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (!btn_s) state_d = ST_HOLD;
            ST_HOLD: begin
                if (btn_s)       state_d = ST_IDLE;
                else if (expire) state_d = FIXED_PULSE ? ST_PULSE : ST_FOLLOW;
            end
            ST_PULSE:     if (expire) state_d = ST_WAIT_REL;
            ST_FOLLOW:    if (btn_s)  state_d = ST_IDLE;
            ST_WAIT_REL:  if (btn_s)  state_d = ST_IDLE;
            ST_TEST_INIT: if (expire) state_d = FIXED_PULSE ? ST_PULSE : ST_OV_HOLD;
            ST_OV_HOLD:   if (!ovp_s) state_d = ST_WAIT_REL;
            default:      state_d = ST_IDLE;
        endcase
        if (ovp_s && !test_q) begin
            state_d = ST_TEST_INIT;
        end
    end

    // State register and test latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            test_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_TEST_INIT) begin
                test_q <= 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_out_n <= 1'b1;
        end else begin
            rst_out_n <= !((state_d == ST_PULSE) || (state_d == ST_FOLLOW) ||
                           (state_d == ST_OV_HOLD));
        end
    end

    assign test_mode = test_q;

endmodule

// File: rtl/lpress_rst_ctrl_chk.sv
module lpress_rst_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_ms,
    input logic btn_s,
    input logic rst_out_n,
    input logic test_mode
);

    // R1: power-on reset leaves output released and test mode clear
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rst_out_n && !test_mode));

    // R9: test mode never drops without power-on reset
    a_r9_sticky_test: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |=> test_mode);

    // R3: reset asserts only on an edge carrying a tick
    a_r3_assert_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> $past(tick_ms));

    // R2: outside test mode, reset asserts only while the button is held
    a_r2_needs_press: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_out_n) && !test_mode) |-> $past(!btn_s));

    // R7: entering test mode releases the reset output
    a_r7_entry_released: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> rst_out_n);

endmodule

bind lpress_rst_ctrl lpress_rst_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_ms  (tick_ms),
    .btn_s    (btn_s),
    .rst_out_n(rst_out_n),
    .test_mode(test_mode)
);

// File: tb/lpress_rst_ctrl_test.sv
module lpress_rst_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD  = 256;
    localparam int INIT  = 6;
    localparam int PULSE = 5;
    localparam int SHORT = HOLD >> 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic btn_n = 1'b1;
    logic ovp = 1'b0;
    logic tick = 1'b0;
    logic fx_rst_n, fx_test, fo_rst_n, fo_test;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpress_rst_ctrl #(.HOLD_MS(HOLD), .TEST_INIT_MS(INIT), .PULSE_MS(PULSE),
                      .FIXED_PULSE(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .ovp_flag(ovp), .tick_ms(tick),
        .rst_out_n(fx_rst_n), .test_mode(fx_test));

    lpress_rst_ctrl #(.HOLD_MS(HOLD), .TEST_INIT_MS(INIT), .PULSE_MS(PULSE),
                      .FIXED_PULSE(1'b0)) uut_follow (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .ovp_flag(ovp), .tick_ms(tick),
        .rst_out_n(fo_rst_n), .test_mode(fo_test));

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            cyc(2);
        end
    endtask

    task automatic press();
        btn_n = 1'b0;
        cyc(4);
    endtask

    task automatic release_btn();
        btn_n = 1'b1;
        cyc(4);
    endtask

    task automatic por();
        rst_n = 1'b0;
        btn_n = 1'b1;
        ovp   = 1'b0;
        tick  = 1'b0;
        cyc(3);
        chk("R1 reset out fixed", fx_rst_n, 1'b1);
        chk("R1 reset test fixed", fx_test, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 after release out follow", fo_rst_n, 1'b1);
        chk("R1 after release test follow", fo_test, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        por();

        // R2: short presses of many lengths never reach the output
        for (int k = 0; k < HOLD; k++) begin
            if (k <= 12 || k >= HOLD - 4) begin
                press();
                ticks(k);
                chk("R2 short press fixed", fx_rst_n, 1'b1);
                chk("R2 short press follow", fo_rst_n, 1'b1);
                release_btn();
                chk("R2 after release", fx_rst_n & fo_rst_n, 1'b1);
            end
        end

        // R3: full hold, early release; R5 fixed pulse, R4 follow
        press();
        ticks(HOLD - 1);
        chk("R3 one tick short fixed", fx_rst_n, 1'b1);
        chk("R3 one tick short follow", fo_rst_n, 1'b1);
        ticks(1);
        chk("R3 asserted fixed", fx_rst_n, 1'b0);
        chk("R3 asserted follow", fo_rst_n, 1'b0);
        release_btn();
        chk("R4 follow released", fo_rst_n, 1'b1);
        chk("R5 fixed still asserted after release", fx_rst_n, 1'b0);
        ticks(PULSE - 1);
        chk("R5 fixed before pulse end", fx_rst_n, 1'b0);
        ticks(1);
        chk("R5 fixed pulse ended", fx_rst_n, 1'b1);

        // R5/R6: full hold kept long after the pulse
        press();
        ticks(HOLD);
        chk("R3 second assert fixed", fx_rst_n, 1'b0);
        ticks(PULSE);
        chk("R5 held pulse ended", fx_rst_n, 1'b1);
        chk("R4 follow held stays asserted", fo_rst_n, 1'b0);
        ticks(HOLD + 44);
        chk("R6 no retrigger while held", fx_rst_n, 1'b1);
        release_btn();
        chk("R4 follow released late", fo_rst_n, 1'b1);
        press();
        ticks(HOLD - 1);
        chk("R6 repress needs full delay", fx_rst_n, 1'b1);
        ticks(1);
        chk("R6 repress asserts", fx_rst_n, 1'b0);
        release_btn();
        ticks(PULSE);
        chk("R6 pulse over", fx_rst_n, 1'b1);

        // R7: overvoltage entry
        ovp = 1'b1;
        cyc(4);
        chk("R7 test flag fixed", fx_test, 1'b1);
        chk("R7 test flag follow", fo_test, 1'b1);
        ticks(INIT - 1);
        chk("R7 init not expired", fx_rst_n & fo_rst_n, 1'b1);
        ticks(1);
        chk("R7 init asserted fixed", fx_rst_n, 1'b0);
        chk("R7 init asserted follow", fo_rst_n, 1'b0);
        ticks(PULSE);
        chk("R7 fixed pulse ended under ovp", fx_rst_n, 1'b1);
        chk("R7 follow holds under ovp", fo_rst_n, 1'b0);
        ovp = 1'b0;
        cyc(4);
        chk("R7 follow released on ovp drop", fo_rst_n, 1'b1);
        chk("R9 test stays fixed", fx_test, 1'b1);
        chk("R9 test stays follow", fo_test, 1'b1);

        // R8: shortened hold in test mode
        press();
        ticks(SHORT - 1);
        chk("R8 short hold not yet", fx_rst_n & fo_rst_n, 1'b1);
        ticks(1);
        chk("R8 short hold fixed", fx_rst_n, 1'b0);
        chk("R8 short hold follow", fo_rst_n, 1'b0);
        release_btn();
        chk("R8 follow released", fo_rst_n, 1'b1);
        ticks(PULSE);
        chk("R8 fixed pulse over", fx_rst_n, 1'b1);
        ovp = 1'b1;
        cyc(4);
        ticks(INIT + 2);
        chk("R9 no re-entry fixed", fx_rst_n, 1'b1);
        chk("R9 no re-entry follow", fo_rst_n, 1'b1);
        ovp = 1'b0;
        cyc(4);

        // R9: only power-on reset leaves test mode
        por();
        chk("R9 cleared by reset", fx_test | fo_test, 1'b0);
        press();
        ticks(SHORT);
        chk("R9 normal delay back", fx_rst_n & fo_rst_n, 1'b1);
        release_btn();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule